// File: doc/BRIEF.md
# Prefixed Shift, Rotate and Bit-Manipulation Unit

This combinational unit executes the second byte of a two-byte prefixed opcode on one 8-bit operand. It decodes the sub-opcode into one of eight shift or rotate operations, a single-bit test, a single-bit clear or a single-bit set. It returns the new operand value, the four condition flags, a write-back enable and the operand-select field that the register file uses to fetch and store the operand.

A mode input reuses the same datapath for the four short accumulator rotates. In that mode the accumulator is always selected and the zero flag is always cleared. The register file, the memory operand path and the cycle timing sit outside the unit. The flags travel as one 4-bit vector: bit 3 zero (Z), bit 2 subtract (N), bit 1 half-carry (H), bit 0 carry (C).

Top module: `pfx_bitops`

## Requirements
- R1: With `acc_rot`=0, `opnd_sel` equals `op_code[2:0]`, whose codes 0..7 mean B, C, D, E, H, L, memory at HL, A. With `acc_rot`=1, `opnd_sel` is 7 (A).
- R2: With `op_code[7:6]`=00 and `op_code[5:3]`=0, the result is the operand rotated left by one, and C receives old bit 7. With `op_code[5:3]`=1, the result is the operand rotated right by one, and C receives old bit 0.
- R3: With `op_code[5:3]`=2, the operand shifts left and the incoming C (`flags_in[0]`) enters bit 0. With `op_code[5:3]`=3, the operand shifts right and the incoming C enters bit 7. In both cases C receives the bit shifted out.
- R4: `op_code[5:3]`=4 shifts left and fills bit 0 with zero. 5 shifts right and keeps bit 7. 7 shifts right and fills bit 7 with zero. In all three, C receives the bit shifted out.
- R5: `op_code[5:3]`=6 exchanges the two nibbles and clears C.
- R6: Every operation in the group with `op_code[7:6]`=00 clears N and H, sets Z exactly when the result is zero, and asserts `wr_en`.
- R7: With `acc_rot`=1, only `op_code[4:3]` is decoded: 0, 1, 2 and 3 select the R2/R3 rotates (rotate left, rotate right, left through carry, right through carry). Z is forced to 0, N and H are cleared, C is as in R2/R3, and `wr_en` is 1.
- R8: With `op_code[7:6]`=01, the bit `op_code[5:3]` is tested. Z becomes the inverse of that bit, N=0, H=1, C keeps `flags_in[0]`, `wr_en`=0, and the result equals the operand.
- R9: With `op_code[7:6]`=10, bit `op_code[5:3]` is cleared. With 11, that bit is set. In both cases `flags_out` equals `flags_in` and `wr_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 8 | Sub-opcode (or short rotate opcode when acc_rot=1) |
| acc_rot | input | 1 | 1 selects the accumulator-rotate mode |
| opnd | input | DW | Operand value |
| flags_in | input | 4 | Current flags {Z,N,H,C} |
| result | output | DW | New operand value |
| flags_out | output | 4 | New flags {Z,N,H,C} |
| wr_en | output | 1 | Result must be written back |
| opnd_sel | output | 3 | Operand register select |

## Verification
Random sub-opcodes, operands and incoming flags cover every operation and every operand select, with incoming carry both 0 and 1. This separates the rotates through carry from the rotates through themselves, and the arithmetic right shift from the logical one. Directed cases use operands 0x00, 0x80, 0x01 and 0xFF. These show the zero flag following the result in prefixed mode and staying cleared in accumulator mode, and a bit test on a zero operand giving Z=1. Bit set and clear run with random flags to show that the flags pass through unchanged.

// File: rtl/pfx_bitops.sv
module pfx_bitops #(
  parameter int DW = 8
) (
  input  logic [7:0]    op_code,
  input  logic          acc_rot,
  input  logic [DW-1:0] opnd,
  input  logic [3:0]    flags_in,
  output logic [DW-1:0] result,
  output logic [3:0]    flags_out,
  output logic          wr_en,
  output logic [2:0]    opnd_sel
);
  localparam int HW = DW / 2;

  logic [1:0]    grp;
  logic [2:0]    fn;
  logic [DW-1:0] mask;
  logic          c_in, c_out;
  logic [DW-1:0] sh;

  assign grp      = acc_rot ? 2'b00 : op_code[7:6];
  assign fn       = acc_rot ? {1'b0, op_code[4:3]} : op_code[5:3];
  assign opnd_sel = acc_rot ? 3'd7 : op_code[2:0];
  assign c_in     = flags_in[0];
  assign mask     = {{(DW-1){1'b0}}, 1'b1} << fn;

  always_comb begin
    sh    = opnd;
    c_out = 1'b0;
    case (fn)
      3'd0: begin sh = {opnd[DW-2:0], opnd[DW-1]};  c_out = opnd[DW-1]; end
      3'd1: begin sh = {opnd[0], opnd[DW-1:1]};     c_out = opnd[0];    end
      3'd2: begin sh = {opnd[DW-2:0], c_in};        c_out = opnd[DW-1]; end
      3'd3: begin sh = {c_in, opnd[DW-1:1]};        c_out = opnd[0];    end
      3'd4: begin sh = {opnd[DW-2:0], 1'b0};        c_out = opnd[DW-1]; end
      3'd5: begin sh = {opnd[DW-1], opnd[DW-1:1]};  c_out = opnd[0];    end
      3'd6: begin sh = {opnd[HW-1:0], opnd[DW-1:HW]}; c_out = 1'b0;     end
      default: begin sh = {1'b0, opnd[DW-1:1]};     c_out = opnd[0];    end
    endcase
  end

  always_comb begin
    case (grp)
      2'b00: begin
        result    = sh;
        flags_out = {~acc_rot & (sh == '0), 1'b0, 1'b0, c_out};
        wr_en     = 1'b1;
      end
      2'b01: begin
        result    = opnd;
        flags_out = {~opnd[fn], 1'b0, 1'b1, c_in};
        wr_en     = 1'b0;
      end
      2'b10: begin
        result    = opnd & ~mask;
        flags_out = flags_in;
        wr_en     = 1'b1;
      end
      default: begin
        result    = opnd | mask;
        flags_out = flags_in;
        wr_en     = 1'b1;
      end
    endcase
  end
endmodule

module pfx_bitops_chk #(
  parameter int DW = 8
) (
  input logic [7:0]    op_code,
  input logic          acc_rot,
  input logic [DW-1:0] opnd,
  input logic [3:0]    flags_in,
  input logic [DW-1:0] result,
  input logic [3:0]    flags_out,
  input logic          wr_en,
  input logic [2:0]    opnd_sel
);
  localparam int HW = DW / 2;

  always_comb begin
    p_sel_r1: assert (opnd_sel == (acc_rot ? 3'd7 : op_code[2:0]));
    if (!acc_rot && op_code[7:6] == 2'b00) begin
      p_shift_flags_r6: assert (flags_out[2:1] == 2'b00 && wr_en
                                && flags_out[3] == (result == '0));
    end
    if (!acc_rot && op_code[7:6] == 2'b00 && op_code[5:3] == 3'd6) begin
      p_swap_r5: assert (result == {opnd[HW-1:0], opnd[DW-1:HW]} && !flags_out[0]);
    end
    if (acc_rot) begin
      p_acc_zero_r7: assert (!flags_out[3] && flags_out[2:1] == 2'b00 && wr_en);
    end
    if (!acc_rot && op_code[7:6] == 2'b01) begin
      p_bit_test_r8: assert (!wr_en && result == opnd && flags_out[2:0] == {2'b01, flags_in[0]});
    end
    if (!acc_rot && op_code[7]) begin
      p_setres_keep_r9: assert (wr_en && flags_out == flags_in
                                && $countones(result ^ opnd) <= 1);
    end
  end
endmodule

bind pfx_bitops pfx_bitops_chk #(.DW(DW)) chk_i (.*);

// File: tb/pfx_bitops_tb_top.sv
module pfx_bitops_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic [7:0] op_code;
  logic acc_rot;
  logic [7:0] opnd;
  logic [3:0] flags_in;
  logic [7:0] result;
  logic [3:0] flags_out;
  logic wr_en;
  logic [2:0] opnd_sel;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfx_bitops dut_i (.op_code(op_code), .acc_rot(acc_rot), .opnd(opnd), .flags_in(flags_in),
                    .result(result), .flags_out(flags_out), .wr_en(wr_en), .opnd_sel(opnd_sel));

  function automatic logic [7:0] exp_res(logic [7:0] op, logic ar, logic [7:0] v, logic ci);
    int f = ar ? int'(op[4:3]) : int'(op[5:3]);
    int g = ar ? 0 : int'(op[7:6]);
    logic [7:0] r;
    if (g == 1) return v;
    if (g == 2) begin r = v; r[f] = 1'b0; return r; end
    if (g == 3) begin r = v; r[f] = 1'b1; return r; end
    case (f)
      0: r = (v << 1) | (v >> 7);
      1: r = (v >> 1) | (v << 7);
      2: r = (v << 1) | {7'd0, ci};
      3: r = (v >> 1) | {ci, 7'd0};
      4: r = v << 1;
      5: r = (v >> 1) | (v & 8'h80);
      6: r = {v[3:0], v[7:4]};
      default: r = v >> 1;
    endcase
    return r;
  endfunction

  function automatic logic [3:0] exp_flg(logic [7:0] op, logic ar, logic [7:0] v, logic [3:0] fi);
    int f = ar ? int'(op[4:3]) : int'(op[5:3]);
    int g = ar ? 0 : int'(op[7:6]);
    logic c;
    logic [7:0] r;
    if (g == 1) return {~v[f], 1'b0, 1'b1, fi[0]};
    if (g >= 2) return fi;
    if (f == 6) c = 1'b0;
    else if (f == 0 || f == 2 || f == 4) c = v[7];
    else c = v[0];
    r = exp_res(op, ar, v, fi[0]);
    return {(!ar && r == 8'd0), 1'b0, 1'b0, c};
  endfunction

  task automatic check(string tag, logic [7:0] op, logic ar, logic [7:0] v, logic [3:0] fi);
    logic [7:0] er;
    logic [3:0] ef;
    logic ew;
    logic [2:0] es;
    @(negedge clk);
    op_code = op; acc_rot = ar; opnd = v; flags_in = fi;
    #1;
    er = exp_res(op, ar, v, fi[0]);
    ef = exp_flg(op, ar, v, fi);
    ew = ar || op[7:6] != 2'b01;
    es = ar ? 3'd7 : op[2:0];
    n_chk++;
    if (result !== er || flags_out !== ef || wr_en !== ew || opnd_sel !== es) begin
      n_err++;
      $display("FAIL %s op=%02h ar=%0b v=%02h fi=%h: got res=%02h flg=%h wr=%0b sel=%0d exp res=%02h flg=%h wr=%0b sel=%0d",
               tag, op, ar, v, fi, result, flags_out, wr_en, opnd_sel, er, ef, ew, es);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!done && cyc > 100000) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op_code = 8'h00; acc_rot = 1'b0; opnd = 8'h00; flags_in = 4'h0;
    // reset-state pattern: rlc of zero, sel B, Z set
    check("R6 zero-in", 8'h00, 1'b0, 8'h00, 4'h0);
    check("R2 rlc 80", 8'h00, 1'b0, 8'h80, 4'h0);
    check("R2 rrc 01", 8'h09, 1'b0, 8'h01, 4'h0);
    check("R3 rl cin", 8'h10, 1'b0, 8'h80, 4'h1);
    check("R3 rr cin", 8'h18, 1'b0, 8'h01, 4'h1);
    check("R4 sla", 8'h20, 1'b0, 8'h80, 4'hF);
    check("R4 sra", 8'h28, 1'b0, 8'h81, 4'h0);
    check("R4 srl", 8'h38, 1'b0, 8'h01, 4'h0);
    check("R5 swap", 8'h37, 1'b0, 8'hA5, 4'h1);
    check("R5 swap zero", 8'h30, 1'b0, 8'h00, 4'hF);
    check("R7 rlca zero", 8'h07, 1'b1, 8'h00, 4'hF);
    check("R7 rra", 8'h1F, 1'b1, 8'h01, 4'h0);
    check("R7 rla", 8'h17, 1'b1, 8'h80, 4'h0);
    check("R8 bit zero", 8'h7E, 1'b0, 8'h00, 4'h1);
    check("R8 bit one", 8'h47, 1'b0, 8'h01, 4'h0);
    check("R9 res", 8'hBF, 1'b0, 8'hFF, 4'hA);
    check("R9 set", 8'hC0, 1'b0, 8'h00, 4'h5);
    check("R1 sel hl", 8'h06, 1'b0, 8'h12, 4'h0);
    for (int i = 0; i < 3000; i++) begin
      logic ar = ($urandom % 8) == 0;
      check(ar ? "R7 rand" : "R1-R9 rand",
            8'($urandom), ar, 8'($urandom), 4'($urandom));
    end
    done = 1;
    finish_run();
  end
endmodule